// File: doc/BRIEF.md
# NAND Flash Register-Indirect Bridge

This block lets a processor drive an 8-bit NAND flash device through a handful of registers. Software first picks an operating mode by writing the mode register. The mode decides whether the command-latch or address-latch pin is raised, whether bytes count toward the error-correction code, and whether data-register reads fetch stored ECC bytes instead of reaching the flash. Each access to the data register then becomes one read or write strobe on the flash pins.

The CPU side uses a request/acknowledge handshake. A data-register access is acknowledged only after its external strobe has finished and one recovery clock has passed. The low time of each strobe is programmable in bus clocks.

ECC arithmetic is done in a separate block. This bridge only tells that block what to do: it sends a clear pulse, a byte-feed strobe and a byte index. A synchronized ready/busy input raises a status bit on its rising edge, and that bit can be turned into an interrupt.

Top module: `nfc_bridge`

## Requirements
- R1: While reset is held and after its release, both strobes are high, the latch pins are low, chip enable (active low) is high, and acknowledge, interrupt, data output enable and ECC feed are all low.
- R2: The mode register (address 1) drives the device pins as follows. Bit 0 drives CLE, bit 1 drives ALE, and bit 7 drives chip enable, which is low when the bit is 1. Examples: 0x91 gives a command phase, 0x92 gives an address phase, and 0xB0 gives a plain data phase.
- R3: When ECC readout is not selected, a write to the data register (address 0) holds the write strobe low for W clocks. W is the value of the strobe-width register (address 2), and a value of 0 acts as 1. While the strobe is low, the written byte is driven with the output enable set, and the read strobe stays high.
- R4: When ECC readout is not selected, a read of the data register holds the read strobe low for W clocks. It returns the flash byte sampled in the last low clock.
- R5: A data-register strobe access is acknowledged by a one-clock pulse in the second clock after the strobe rises, so one high recovery clock comes first. Every other access is acknowledged in the clock after it is accepted.
- R6: With mode bits 7 and 6 both set (for example 0xD0), data-register accesses issue no strobe. Each read returns the ECC byte at the current index and then advances the index, which counts 0 to ECC_BYTES-1 and wraps. Writes are ignored. Any mode write resets the index to 0.
- R7: A mode write with bit 7 clear and bits 6..4 all set (for example 0x70) pulses the ECC clear output for exactly one clock, in the clock after the acknowledge.
- R8: A completed data strobe in a mode that has bit 5 set and bits 6, 1 and 0 clear pulses the ECC feed output for one clock, in the recovery clock. The pulse carries the written or read byte. No other access pulses the feed output.
- R9: The bus-separate output follows mode bit 3.
- R10: A rising edge of the synchronized ready input sets the status bit, which reads as bit 0 at address 4. Writing a 1 to bit 0 of that address clears it. The interrupt is the registered AND of the status bit with mask bits 0 and 7 (address 3); writing 0x81 enables it.
- R11: Register reads return the last value written to the mode and mask registers, and the strobe width zero-extended. The width resets to DEF_STRB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until acknowledge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with acknowledge |
| cpu_ack | output | 1 | One-clock completion pulse |
| nd_ce_n | output | 1 | Flash chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_dq_o | output | 8 | Byte driven to the flash |
| nd_dq_oe | output | 1 | Output enable for nd_dq_o |
| nd_dq_i | input | 8 | Byte from the flash |
| nd_rdy | input | 1 | Ready/busy from the flash, asynchronous |
| bus_sep | output | 1 | Separated-bus connection enable |
| irq | output | 1 | Ready interrupt |
| ecc_clr | output | 1 | Clear pulse to the ECC block |
| ecc_feed_vld | output | 1 | Byte strobe to the ECC block |
| ecc_feed_byte | output | 8 | Byte for the ECC block |
| ecc_idx | output | IDX_W | Index of the ECC byte being read out |
| ecc_rdata | input | 8 | ECC byte at ecc_idx |

## Verification
The bench builds the bridge with STRB_W=4, ECC_BYTES=6, SYNC_STAGES=2 and DEF_STRB=3. A 4-bit width register makes it cheap to run strobes at the zero-as-one boundary and at 1, 2, 3 and 5 clocks. Six ECC bytes mean that eight readout reads pass through the index wrap. Two sync stages keep the ready-to-interrupt latency short, so the masked and unmasked interrupt cases each fit in a few clocks.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] ADR_DATA = 3'd0;
  localparam logic [AW-1:0] ADR_MODE = 3'd1;
  localparam logic [AW-1:0] ADR_STRB = 3'd2;
  localparam logic [AW-1:0] ADR_MASK = 3'd3;
  localparam logic [AW-1:0] ADR_STAT = 3'd4;

  localparam int MB_CLE  = 0;
  localparam int MB_ALE  = 1;
  localparam int MB_BSEP = 3;
  localparam int MB_ACC  = 5;
  localparam int MB_ERD  = 6;
  localparam int MB_CE   = 7;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_ACK} seq_st_t;
endpackage

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  input  logic              ecc_rd_mode,
  input  logic [STRB_W-1:0] strb_w,
  input  logic [7:0]        dq_in,
  input  logic [7:0]        reg_rdata,
  input  logic [7:0]        ecc_rdata,
  output logic              ack,
  output logic [7:0]        rdata,
  output logic              re_n,
  output logic              we_n,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic              reg_wr,
  output logic [AW-1:0]     reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              xfer_vld,
  output logic [7:0]        xfer_byte,
  output logic              ecc_adv
);
  seq_st_t           st;
  logic [STRB_W-1:0] cnt;
  logic              is_wr;
  logic              strobe_acc;

  assign strobe_acc = (addr == ADR_DATA) && !ecc_rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      ack       <= 1'b0;
      rdata     <= '0;
      re_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      xfer_vld  <= 1'b0;
      xfer_byte <= '0;
      ecc_adv   <= 1'b0;
    end else begin
      ack      <= 1'b0;
      reg_wr   <= 1'b0;
      xfer_vld <= 1'b0;
      ecc_adv  <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          if (strobe_acc) begin
            cnt   <= (strb_w == '0) ? STRB_W'(1) : strb_w;
            is_wr <= we;
            st    <= S_LOW;
            if (we) begin
              we_n  <= 1'b0;
              dq_o  <= wdata;
              dq_oe <= 1'b1;
            end else begin
              re_n  <= 1'b0;
            end
          end else begin
            ack <= 1'b1;
            st  <= S_ACK;
            if (we) begin
              reg_wr    <= 1'b1;
              reg_addr  <= addr;
              reg_wdata <= wdata;
            end else if (addr == ADR_DATA) begin
              rdata   <= ecc_rdata;
              ecc_adv <= 1'b1;
            end else begin
              rdata <= reg_rdata;
            end
          end
        end
        S_LOW: begin
          if (cnt == STRB_W'(1)) begin
            we_n      <= 1'b1;
            re_n      <= 1'b1;
            xfer_vld  <= 1'b1;
            xfer_byte <= is_wr ? dq_o : dq_in;
            if (!is_wr) rdata <= dq_in;
            st <= S_HIGH;
          end else begin
            cnt <= cnt - STRB_W'(1);
          end
        end
        S_HIGH: begin
          ack   <= 1'b1;
          dq_oe <= 1'b0;
          st    <= S_ACK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  // R5
  ack_recov_chk: assert property (@(posedge clk) disable iff (rst) ack |-> ($past(we_n) && $past(re_n)));
  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst) !we_n |-> dq_oe);
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int STRB_W    = 4,
  parameter int ECC_BYTES = 6,
  parameter int DEF_STRB  = 3,
  localparam int IDX_W    = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [AW-1:0]     rd_addr,
  input  logic              ecc_adv,
  input  logic              status,
  output logic [7:0]        reg_rdata,
  output logic [STRB_W-1:0] strb_w,
  output logic              cle,
  output logic              ale,
  output logic              ce_n,
  output logic              bsep,
  output logic              ecc_rd_mode,
  output logic              feed_en,
  output logic              irq_en,
  output logic              ecc_clr,
  output logic [IDX_W-1:0]  ecc_idx,
  output logic              stat_clr
);
  logic [7:0] mode;
  logic [7:0] mask;
  logic [7:0] strb_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      mask    <= '0;
      strb_w  <= STRB_W'(DEF_STRB);
      ecc_clr <= 1'b0;
      ecc_idx <= '0;
    end else begin
      ecc_clr <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          ADR_MODE: begin
            mode    <= reg_wdata;
            ecc_idx <= '0;
            if (!reg_wdata[7] && (reg_wdata[6:4] == 3'b111)) ecc_clr <= 1'b1;
          end
          ADR_STRB: strb_w <= reg_wdata[STRB_W-1:0];
          ADR_MASK: mask   <= reg_wdata;
          default: ;
        endcase
      end else if (ecc_adv) begin
        if (ecc_idx == IDX_W'(ECC_BYTES - 1)) ecc_idx <= '0;
        else ecc_idx <= ecc_idx + IDX_W'(1);
      end
    end
  end

  assign cle         = mode[MB_CLE];
  assign ale         = mode[MB_ALE];
  assign ce_n        = ~mode[MB_CE];
  assign bsep        = mode[MB_BSEP];
  assign ecc_rd_mode = mode[MB_CE] & mode[MB_ERD];
  assign feed_en     = mode[MB_ACC] & ~mode[MB_ERD] & ~mode[MB_CLE] & ~mode[MB_ALE];
  assign irq_en      = mask[0] & mask[7];
  assign stat_clr    = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[0];

  always_comb begin
    strb_ext = '0;
    strb_ext[STRB_W-1:0] = strb_w;
  end

  always_comb begin
    case (rd_addr)
      ADR_MODE: reg_rdata = mode;
      ADR_STRB: reg_rdata = strb_ext;
      ADR_MASK: reg_rdata = mask;
      ADR_STAT: reg_rdata = {7'b0, status};
      default:  reg_rdata = '0;
    endcase
  end

  // R7
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst) ecc_clr |=> !ecc_clr);
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst) 32'(ecc_idx) < ECC_BYTES);
endmodule

// File: rtl/nfc_rdy_irq.sv
module nfc_rdy_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_in,
  input  logic irq_en,
  input  logic stat_clr,
  output logic status,
  output logic irq
);
  logic rdy_s;
  logic rdy_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) rdy_s <= 1'b1;
        else     rdy_s <= rdy_in;
      end
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[SYNC_STAGES-2:0], rdy_in};
      end
      assign rdy_s = sr[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b1;
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      rdy_q <= rdy_s;
      if (rdy_s && !rdy_q) status <= 1'b1;
      else if (stat_clr)   status <= 1'b0;
      irq <= status & irq_en;
    end
  end

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst) irq |-> $past(irq_en));
endmodule

// File: rtl/nfc_bridge.sv
module nfc_bridge
  import nfc_pkg::*;
#(
  parameter int STRB_W      = 4,
  parameter int ECC_BYTES   = 6,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_STRB    = 3,
  localparam int IDX_W      = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [2:0]       cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             cpu_ack,
  output logic             nd_ce_n,
  output logic             nd_cle,
  output logic             nd_ale,
  output logic             nd_re_n,
  output logic             nd_we_n,
  output logic [7:0]       nd_dq_o,
  output logic             nd_dq_oe,
  input  logic [7:0]       nd_dq_i,
  input  logic             nd_rdy,
  output logic             bus_sep,
  output logic             irq,
  output logic             ecc_clr,
  output logic             ecc_feed_vld,
  output logic [7:0]       ecc_feed_byte,
  output logic [IDX_W-1:0] ecc_idx,
  input  logic [7:0]       ecc_rdata
);
  logic              ecc_rd_mode, feed_en, irq_en, stat_clr, status;
  logic [STRB_W-1:0] strb_w;
  logic [7:0]        reg_rdata, reg_wdata;
  logic [AW-1:0]     reg_addr;
  logic              reg_wr, xfer_vld, ecc_adv;

  nfc_seq #(.STRB_W(STRB_W)) i_seq (
    .clk, .rst,
    .req(cpu_req), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
    .ecc_rd_mode, .strb_w, .dq_in(nd_dq_i), .reg_rdata, .ecc_rdata,
    .ack(cpu_ack), .rdata(cpu_rdata), .re_n(nd_re_n), .we_n(nd_we_n),
    .dq_o(nd_dq_o), .dq_oe(nd_dq_oe), .reg_wr, .reg_addr, .reg_wdata,
    .xfer_vld, .xfer_byte(ecc_feed_byte), .ecc_adv
  );

  nfc_regs #(.STRB_W(STRB_W), .ECC_BYTES(ECC_BYTES), .DEF_STRB(DEF_STRB)) i_regs (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .rd_addr(cpu_addr),
    .ecc_adv, .status, .reg_rdata, .strb_w,
    .cle(nd_cle), .ale(nd_ale), .ce_n(nd_ce_n), .bsep(bus_sep),
    .ecc_rd_mode, .feed_en, .irq_en, .ecc_clr, .ecc_idx, .stat_clr
  );

  nfc_rdy_irq #(.SYNC_STAGES(SYNC_STAGES)) i_rdy (
    .clk, .rst, .rdy_in(nd_rdy), .irq_en, .stat_clr, .status, .irq
  );

  assign ecc_feed_vld = xfer_vld & feed_en;
endmodule

// File: tb/test_nfc_bridge.sv
module test_nfc_bridge;
  localparam int STRB_W = 4, ECC_BYTES = 6, DEF_STRB = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0;
  logic [2:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, nd_dq_o, nd_dq_i = 0, ecc_feed_byte, ecc_rdata;
  logic cpu_ack, nd_ce_n, nd_cle, nd_ale, nd_re_n, nd_we_n, nd_dq_oe;
  logic nd_rdy = 1'b1, bus_sep, irq, ecc_clr, ecc_feed_vld;
  logic [2:0] ecc_idx;

  int checks = 0, errors = 0;
  logic [7:0] m_mode = 0;
  int m_w = DEF_STRB;
  bit mon_on = 0, done = 0;
  logic [7:0] q;

  always #4 clk = ~clk;
  assign ecc_rdata = 8'hE0 + 8'(ecc_idx);

  nfc_bridge #(.STRB_W(STRB_W), .ECC_BYTES(ECC_BYTES), .SYNC_STAGES(2), .DEF_STRB(DEF_STRB))
  i_nfc_bridge (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // continuous pin model for R2 / R9
  always begin
    @(negedge clk); #1;
    if (mon_on) begin
      chk("R2 cle", nd_cle, m_mode[0]);
      chk("R2 ale", nd_ale, m_mode[1]);
      chk("R2 ce_n", nd_ce_n, !m_mode[7]);
      chk("R9 bus_sep", bus_sep, m_mode[3]);
    end
  end

  task automatic cpu(input bit we, input logic [2:0] a, input logic [7:0] d,
                     input logic [7:0] din, output logic [7:0] rd);
    bit data, feed, exp_ack;
    int wp, n;
    @(negedge clk);
    data = (a == 0) && !(m_mode[7] && m_mode[6]);
    feed = data && m_mode[5] && !m_mode[6] && !m_mode[0] && !m_mode[1];
    wp = (m_w == 0) ? 1 : m_w;
    nd_dq_i = din; cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    n = 0;
    do begin
      @(negedge clk); n++;
      exp_ack = data ? (n == wp + 2) : (n == 1);
      chk("R5 ack timing", cpu_ack, exp_ack);
      chk("R3 we_n", nd_we_n, !(data && we && n <= wp));
      chk("R4 re_n", nd_re_n, !(data && !we && n <= wp));
      if (data && we && n <= wp) begin
        chk("R3 dq_o", nd_dq_o, d);
        chk("R3 dq_oe", nd_dq_oe, 1);
      end
      chk("R8 feed_vld", ecc_feed_vld, feed && (n == wp + 1));
      if (feed && n == wp + 1) chk("R8 feed_byte", ecc_feed_byte, we ? d : din);
    end while (!cpu_ack && n < 40);
    rd = cpu_rdata;
    cpu_req = 0;
  endtask

  task automatic wr_mode(input logic [7:0] d);
    logic [7:0] t;
    cpu(1, 3'd1, d, 8'h00, t);
    @(negedge clk);
    chk("R7 ecc_clr", ecc_clr, (!d[7] && d[6:4] == 3'b111));
    m_mode = d;
  endtask

  task automatic wr_strb(input int w);
    logic [7:0] t;
    cpu(1, 3'd2, 8'(w), 8'h00, t);
    m_w = w;
    cpu(0, 3'd2, 8'h00, 8'h00, t);
    chk("R11 strobe readback", t, w);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 we_n", nd_we_n, 1); chk("R1 re_n", nd_re_n, 1);
    chk("R1 cle", nd_cle, 0); chk("R1 ale", nd_ale, 0); chk("R1 ce_n", nd_ce_n, 1);
    chk("R1 ack", cpu_ack, 0); chk("R1 irq", irq, 0); chk("R1 oe", nd_dq_oe, 0);
    chk("R1 feed", ecc_feed_vld, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 we_n post", nd_we_n, 1);
    mon_on = 1;

    cpu(0, 3'd2, 8'h00, 8'h00, q);
    chk("R11 strobe reset", q, DEF_STRB);
    wr_strb(2);
    wr_mode(8'h70);                       // R7
    wr_mode(8'h91);                       // R2 command
    cpu(1, 3'd0, 8'h80, 8'h00, q);
    wr_mode(8'h92);                       // R2 address
    wr_strb(0);                           // R3 zero acts as one
    cpu(1, 3'd0, 8'h12, 8'h00, q);
    wr_strb(1);
    cpu(1, 3'd0, 8'h34, 8'h00, q);
    cpu(1, 3'd0, 8'h56, 8'h00, q);
    wr_mode(8'hB0);                       // R8 data mode
    wr_strb(5);
    cpu(1, 3'd0, 8'hA5, 8'h00, q);
    cpu(1, 3'd0, 8'h5A, 8'h00, q);
    wr_strb(3);
    cpu(1, 3'd0, 8'hC3, 8'h00, q);
    cpu(0, 3'd0, 8'h00, 8'h3C, q); chk("R4 read data", q, 8'h3C);
    cpu(0, 3'd0, 8'h00, 8'h99, q); chk("R4 read data", q, 8'h99);
    wr_mode(8'hB8);                       // R9 bus separate
    cpu(1, 3'd0, 8'h77, 8'h00, q);
    wr_mode(8'hD0);                       // R6 ECC readout
    for (int i = 0; i < 8; i++) begin
      cpu(0, 3'd0, 8'h00, 8'h11, q);
      chk("R6 ecc byte", q, 8'hE0 + (i % ECC_BYTES));
    end
    cpu(1, 3'd0, 8'hFF, 8'h00, q);        // R6 write ignored
    cpu(0, 3'd0, 8'h00, 8'h11, q);
    chk("R6 after ignored write", q, 8'hE2);
    wr_mode(8'hD0);
    cpu(0, 3'd0, 8'h00, 8'h11, q);
    chk("R6 index reset", q, 8'hE0);
    cpu(0, 3'd1, 8'h00, 8'h00, q);
    chk("R11 mode readback", q, 8'hD0);

    // R10 interrupt
    cpu(1, 3'd3, 8'h81, 8'h00, q);
    cpu(0, 3'd3, 8'h00, 8'h00, q);
    chk("R11 mask readback", q, 8'h81);
    @(negedge clk); nd_rdy = 0;
    repeat (4) @(negedge clk); nd_rdy = 1;
    repeat (6) @(negedge clk);
    chk("R10 irq set", irq, 1);
    cpu(0, 3'd4, 8'h00, 8'h00, q);
    chk("R10 status", q, 1);
    cpu(1, 3'd4, 8'h01, 8'h00, q);
    repeat (3) @(negedge clk);
    chk("R10 irq cleared", irq, 0);
    cpu(1, 3'd3, 8'h01, 8'h00, q);
    nd_rdy = 0;
    repeat (4) @(negedge clk); nd_rdy = 1;
    repeat (6) @(negedge clk);
    chk("R10 irq masked", irq, 0);
    cpu(0, 3'd4, 8'h00, 8'h00, q);
    chk("R10 status while masked", q, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule